// File: doc/BRIEF.md
# Single-Step RISC-V Subset Core

This block is a small non-pipelined processor that runs a narrow slice of the RISC-V integer instruction set: register add, add-immediate, branch-if-equal, and one custom instruction that copies a register to a display output. The core holds a register bank of 32 entries of 32 bits, a program counter that counts whole instructions, and a synchronous-read program ROM whose image is set by a parameter. An instruction decoder drives the control flags. An immediate extractor and an adder complete the datapath.

The rate of execution is set from outside by `step_en`. A two-state controller does the sequencing. In state FETCH the core waits with the ROM output settling on the current program counter. The transition FETCH to EXEC is taken on a cycle where `step_en` is high, and FETCH to FETCH on a cycle where it is low. In state EXEC the fetched instruction is decoded and committed: the register write, the program counter update and the print capture all happen at the single edge that ends EXEC. The transition EXEC to FETCH is unconditional. Because of this, each accepted step commits exactly one instruction, however long `step_en` stays high. A slow step source therefore cannot make an instruction such as an increment apply more than once.

Top module: `step_core`

## Requirements
- R1: A synchronous active-high `rst` sets `pc_out` to 0, `print_data` to 0 and `print_valid` to 0.
- R2: While the controller is in FETCH and `step_en` is low, `pc_out`, the registers and the print output hold. A cycle in FETCH with `step_en` high starts exactly one instruction, which commits at the end of the following cycle.
- R3: A non-branching instruction, or a branch whose operands differ, advances `pc_out` by exactly 1.
- R4: Branch-if-equal has opcode 1100011 and funct3 000, with rs1 at bits 19:15 and rs2 at bits 24:20. The word offset is {bit31, bit7, bits 30:25, bits 11:8}, sign-extended and not shifted. When the two registers are equal, the next `pc_out` is the branch address plus that offset, modulo the ROM depth of 32.
- R5: Add-immediate has opcode 0010011 and funct3 000, with rd at bits 11:7 and rs1 at bits 19:15. It writes rs1 plus bits 31:20 sign-extended.
- R6: Register add has opcode 0110011, funct3 000 and bits 31:25 zero. It writes rs1 plus rs2 (rs2 at bits 24:20).
- R7: Register x0 always reads as 0. Writes aimed at it have no effect.
- R8: The print instruction has opcode 1111111, with its source register at bits 19:15. One cycle after its commit edge, `print_data` holds that register's value and `print_valid` is high for exactly one cycle.
- R9: Each instruction writes the register bank at most once. A loop whose counter is incremented by add-immediate therefore exits after the programmed count.
- R10: Any other opcode writes no register and advances `pc_out` by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step request, sampled in FETCH |
| pc_out | output | 5 | Address of the current instruction, in instruction units |
| print_data | output | 32 | Value captured by the last print instruction |
| print_valid | output | 1 | One-cycle strobe marking a new print value |

## Verification
The hardest conditions to reach from the ports are a write aimed at x0, an unsupported opcode landing on a live register, and an exit branch that depends on a counter incremented exactly once per step. No input reaches these directly. The bench loads its own program image through the ROM parameter. A short prologue writes to x0 and prints it, builds a negative value with add-immediate and add, and runs an unsupported load-format word against that register before printing it again. The image then continues into the Fibonacci loop. The bench also holds `step_en` low for long stretches, both at reset and mid-run, to show that nothing advances while the core waits for a step.

// File: rtl/stepcore_pkg.sv
package stepcore_pkg;

    localparam int XLEN      = 32;
    localparam int REG_CNT   = 32;
    localparam int RADDR_W   = $clog2(REG_CNT);
    localparam int IMG_WORDS = 32;
    localparam int PC_W      = $clog2(IMG_WORDS);

    typedef logic [IMG_WORDS-1:0][XLEN-1:0] rom_image_t;

    localparam logic [6:0] OPC_ALU_REG = 7'b0110011;
    localparam logic [6:0] OPC_ALU_IMM = 7'b0010011;
    localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
    localparam logic [6:0] OPC_PRINT   = 7'b1111111;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } state_t;

    typedef struct packed {
        logic reg_write;
        logic use_imm;
        logic is_branch;
        logic is_print;
    } ctrl_t;

    function automatic logic [31:0] enc_addi(input int rd, input int rs1, input int imm);
        logic [11:0] v;
        v = 12'(imm);
        return {v, 5'(rs1), 3'b000, 5'(rd), OPC_ALU_IMM};
    endfunction

    function automatic logic [31:0] enc_add(input int rd, input int rs1, input int rs2);
        return {7'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), OPC_ALU_REG};
    endfunction

    // word offset w: w[11]->31, w[10]->7, w[9:4]->30:25, w[3:0]->11:8
    function automatic logic [31:0] enc_beq(input int rs1, input int rs2, input int off);
        logic [11:0] w;
        w = 12'(off);
        return {w[11], w[9:4], 5'(rs2), 5'(rs1), 3'b000, w[3:0], w[10], OPC_BRANCH};
    endfunction

    function automatic logic [31:0] enc_print(input int rs1);
        return {12'b0, 5'(rs1), 3'b000, 5'b0, OPC_PRINT};
    endfunction

    // Fibonacci loop placed at word 'base'; every other word is a self-branch.
    function automatic rom_image_t fib_image(input int base);
        rom_image_t img;
        for (int k = 0; k < IMG_WORDS; k++) img[k] = enc_beq(0, 0, 0);
        img[base+0]  = enc_addi(1, 0, 0);
        img[base+1]  = enc_addi(2, 0, 1);
        img[base+2]  = enc_addi(4, 0, 0);
        img[base+3]  = enc_addi(5, 0, 10);
        img[base+4]  = enc_beq(4, 5, 7);
        img[base+5]  = enc_add(3, 1, 2);
        img[base+6]  = enc_addi(1, 2, 0);
        img[base+7]  = enc_addi(2, 3, 0);
        img[base+8]  = enc_print(3);
        img[base+9]  = enc_addi(4, 4, 1);
        img[base+10] = enc_beq(0, 0, -6);
        img[base+11] = enc_print(3);
        img[base+12] = enc_beq(0, 0, -1);
        return img;
    endfunction

endpackage

// File: rtl/stepcore_rom.sv
module stepcore_rom
    import stepcore_pkg::*;
#(
    parameter rom_image_t IMAGE = fib_image(0)
) (
    input  logic            clk,
    input  logic [PC_W-1:0] addr,
    output logic [XLEN-1:0] data_q
);

    always_ff @(posedge clk) begin
        data_q <= IMAGE[addr];
    end

endmodule

// File: rtl/stepcore_regbank.sv
module stepcore_regbank
    import stepcore_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [RADDR_W-1:0] wa,
    input  logic [XLEN-1:0]    wd,
    input  logic [RADDR_W-1:0] ra,
    input  logic [RADDR_W-1:0] rb,
    output logic [XLEN-1:0]    qa,
    output logic [XLEN-1:0]    qb
);

    logic [XLEN-1:0] slot [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_slot
        if (g == 0) begin : g_zero
            assign slot[g] = '0;
        end else begin : g_store
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (we && wa == RADDR_W'(g)) q <= wd;
            end
            assign slot[g] = q;
        end
    end

    assign qa = slot[ra];
    assign qb = slot[rb];

endmodule

// File: rtl/stepcore_decode.sv
module stepcore_decode
    import stepcore_pkg::*;
(
    input  logic [XLEN-1:0]    instr,
    output ctrl_t              ctrl,
    output logic [RADDR_W-1:0] rd,
    output logic [RADDR_W-1:0] rs1,
    output logic [RADDR_W-1:0] rs2,
    output logic [XLEN-1:0]    imm
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;

    assign opcode = instr[6:0];
    assign funct3 = instr[14:12];
    assign funct7 = instr[31:25];
    assign rd     = instr[11:7];
    assign rs1    = instr[19:15];
    assign rs2    = instr[24:20];

    always_comb begin
        ctrl = '0;
        imm  = '0;
        unique case (opcode)
            OPC_ALU_IMM: begin
                if (funct3 == 3'b000) begin
                    ctrl.reg_write = 1'b1;
                    ctrl.use_imm   = 1'b1;
                end
                imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
            end
            OPC_ALU_REG: begin
                ctrl.reg_write = (funct3 == 3'b000) && (funct7 == 7'b0);
            end
            OPC_BRANCH: begin
                ctrl.is_branch = (funct3 == 3'b000);
                imm = {{(XLEN-12){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8]};
            end
            OPC_PRINT: begin
                ctrl.is_print = 1'b1;
            end
            default: begin
                ctrl = '0;
            end
        endcase
    end

endmodule

// File: rtl/stepcore_alu.sv
module stepcore_alu
    import stepcore_pkg::*;
(
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b_reg,
    input  logic [XLEN-1:0] op_b_imm,
    input  logic            use_imm,
    output logic [XLEN-1:0] sum,
    output logic            equal
);

    logic [XLEN-1:0] op_b;

    assign op_b  = use_imm ? op_b_imm : op_b_reg;
    assign sum   = op_a + op_b;
    assign equal = (op_a == op_b_reg);

endmodule

// File: rtl/step_core.sv
module step_core
    import stepcore_pkg::*;
#(
    parameter rom_image_t PROGRAM = fib_image(0)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    output logic [PC_W-1:0] pc_out,
    output logic [XLEN-1:0] print_data,
    output logic            print_valid
);

    state_t             state_q, state_nx;
    logic               in_exec;
    logic [PC_W-1:0]    pc_q, pc_nx;
    logic [XLEN-1:0]    instr;
    ctrl_t              ctrl;
    logic [RADDR_W-1:0] rd, rs1, rs2;
    logic [XLEN-1:0]    imm, rs1_data, rs2_data, alu_sum;
    logic               eq, take_branch, rf_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FETCH: state_nx = step_en ? ST_EXEC : ST_FETCH;
            ST_EXEC:  state_nx = ST_FETCH;
            default:  state_nx = ST_FETCH;
        endcase
    end

    assign in_exec = (state_q == ST_EXEC);

    stepcore_rom #(.IMAGE(PROGRAM)) u_rom (
        .clk    (clk),
        .addr   (pc_q),
        .data_q (instr)
    );

    stepcore_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl),
        .rd    (rd),
        .rs1   (rs1),
        .rs2   (rs2),
        .imm   (imm)
    );

    stepcore_regbank u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (rd),
        .wd  (alu_sum),
        .ra  (rs1),
        .rb  (rs2),
        .qa  (rs1_data),
        .qb  (rs2_data)
    );

    stepcore_alu u_alu (
        .op_a     (rs1_data),
        .op_b_reg (rs2_data),
        .op_b_imm (imm),
        .use_imm  (ctrl.use_imm),
        .sum      (alu_sum),
        .equal    (eq)
    );

    assign rf_we       = in_exec && ctrl.reg_write;
    assign take_branch = ctrl.is_branch && eq;
    assign pc_nx       = take_branch ? (pc_q + imm[PC_W-1:0]) : (pc_q + 1'b1);

    // program counter and print outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q        <= '0;
            print_data  <= '0;
            print_valid <= 1'b0;
        end else begin
            print_valid <= in_exec && ctrl.is_print;
            if (in_exec) begin
                pc_q <= pc_nx;
                if (ctrl.is_print) print_data <= rs1_data;
            end
        end
    end

    assign pc_out = pc_q;

endmodule

// File: rtl/stepcore_sva.sv
module stepcore_sva
    import stepcore_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic               in_exec,
    input logic [PC_W-1:0]    pc,
    input logic               branch_taken,
    input logic               rf_we,
    input logic [RADDR_W-1:0] ra_addr,
    input logic [XLEN-1:0]    ra_data,
    input logic               print_valid
);

    assert_wait_for_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!in_exec && !step_en) |=> !in_exec);

    assert_pc_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !in_exec |=> $stable(pc));

    assert_seq_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (in_exec && !branch_taken) |=> (pc == PC_W'($past(pc) + 1'b1)));

    assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    assert_x0_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (ra_addr == '0) |-> (ra_data == '0));

    assert_print_after_exec_R8: assert property (@(posedge clk) disable iff (rst)
        print_valid |-> $past(in_exec));

    assert_print_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        print_valid |=> !print_valid);

endmodule

bind step_core stepcore_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .step_en      (step_en),
    .in_exec      (in_exec),
    .pc           (pc_q),
    .branch_taken (take_branch),
    .rf_we        (rf_we),
    .ra_addr      (rs1),
    .ra_data      (rs1_data),
    .print_valid  (print_valid)
);

// File: tb/step_core_test.sv
`timescale 1ns/1ps
module step_core_test;
    import stepcore_pkg::*;

    localparam int FIB_BASE = 6;

    function automatic rom_image_t tb_image();
        rom_image_t img;
        img = fib_image(FIB_BASE);
        img[0] = enc_addi(0, 0, 5);     // attempted write to x0 (R7)
        img[1] = enc_print(0);          // expect 0
        img[2] = enc_addi(6, 0, -3);    // x6 = -3 (R5)
        img[3] = enc_add(7, 6, 6);      // x7 = -6 (R6)
        img[4] = 32'h0000_0383;         // unsupported opcode 0000011, rd=x7 (R10)
        img[5] = enc_print(7);          // expect -6
        return img;
    endfunction

    localparam rom_image_t TB_IMG = tb_image();

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            step_en = 1'b0;
    logic [PC_W-1:0] pc_out;
    logic [XLEN-1:0] print_data;
    logic            print_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int nlog    = 0;
    int double_valid = 0;
    int cycles  = 0;
    logic [XLEN-1:0] log_q [64];
    logic prev_valid = 1'b0;

    always #4 clk = ~clk;

    step_core #(.PROGRAM(TB_IMG)) uut (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .pc_out      (pc_out),
        .print_data  (print_data),
        .print_valid (print_valid)
    );

    // print monitor
    always @(negedge clk) begin
        if (!rst && print_valid) begin
            if (nlog < 64) log_q[nlog] = print_data;
            nlog = nlog + 1;
            if (prev_valid) double_valid = double_valid + 1;
        end
        prev_valid = print_valid && !rst;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        rst = 1'b1; step_en = 1'b0;
        wait_cycles(3);
        check("R1 pc_out", 32'(pc_out), 32'd0);
        check("R1 print_data", print_data, 32'd0);
        check("R1 print_valid", 32'(print_valid), 32'd0);
        rst = 1'b0;
        nlog = 0; double_valid = 0;
    endtask

    task automatic t_step_gating();
        wait_cycles(20);
        check("R2 pc holds without step", 32'(pc_out), 32'd0);
        check("R2 no print without step", 32'(nlog), 32'd0);
        step_en = 1'b1;
        wait_cycles(1);
        step_en = 1'b0;
        wait_cycles(1);
        check("R2 R3 one step gives one instruction", 32'(pc_out), 32'd1);
        wait_cycles(10);
        check("R2 pc stays after single step", 32'(pc_out), 32'd1);
    endtask

    task automatic t_program_run();
        logic [31:0] exp [15];
        logic [PC_W-1:0] held;
        int held_log;
        int guard;
        exp[0] = 32'd0;
        exp[1] = 32'hFFFF_FFFA;
        exp[2] = 1;  exp[3] = 2;  exp[4] = 3;  exp[5] = 5;  exp[6] = 8;
        exp[7] = 13; exp[8] = 21; exp[9] = 34; exp[10] = 55; exp[11] = 89;
        exp[12] = 89; exp[13] = 89; exp[14] = 89;
        step_en = 1'b1;
        guard = 0;
        while (nlog < 5 && guard < 2000) begin wait_cycles(1); guard++; end
        step_en = 1'b0;
        wait_cycles(2);
        held = pc_out; held_log = nlog;
        wait_cycles(15);
        check("R2 mid-run pause holds pc", 32'(pc_out), 32'(held));
        check("R2 mid-run pause no print", 32'(nlog), 32'(held_log));
        step_en = 1'b1;
        guard = 0;
        while (nlog < 15 && guard < 4000) begin wait_cycles(1); guard++; end
        check("R8 print count reached", 32'(nlog >= 15), 32'd1);
        check("R7 x0 write ignored", log_q[0], exp[0]);
        check("R5 R6 R10 add path and unsupported opcode", log_q[1], exp[1]);
        for (int k = 2; k < 12; k++)
            check($sformatf("R9 R4 fib term %0d", k-1), log_q[k], exp[k]);
        for (int k = 12; k < 15; k++)
            check("R4 R8 terminal repeat", log_q[k], exp[k]);
        for (int k = 0; k < 6; k++) begin
            wait_cycles(1);
            check("R4 terminal loop pc", 32'((pc_out == 5'(FIB_BASE+11)) || (pc_out == 5'(FIB_BASE+12))), 32'd1);
        end
        check("R8 single-cycle strobe", 32'(double_valid), 32'd0);
    endtask

    task automatic t_reset_midrun();
        int held_log;
        rst = 1'b1;
        wait_cycles(1);
        step_en = 1'b0;
        wait_cycles(1);
        check("R1 mid-run pc", 32'(pc_out), 32'd0);
        check("R1 mid-run print_data", print_data, 32'd0);
        check("R1 mid-run print_valid", 32'(print_valid), 32'd0);
        rst = 1'b0;
        held_log = nlog;
        wait_cycles(10);
        check("R2 idle after reset", 32'(nlog), 32'(held_log));
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset_state();
        t_step_gating();
        t_program_run();
        t_reset_midrun();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule